// File: doc/BRIEF.md
# Multi-Phase Escalation Timer

This block runs a security escalation through a fixed chain of phases once it is triggered. Each phase has its own programmable dwell threshold. A cycle counter runs against the threshold of the active phase. When the counter reaches that threshold, the timer moves to the next phase. Movement is forward only. After the last phase the timer locks into a terminal state, and only reset releases it.

Each phase drives its own request line, gated by a per-phase enable. A disabled phase still uses up its dwell time, but its request line stays low. Next to the timer sits a sticky capture register of the kind a downstream receiver uses. It latches every request it sees at a clock edge and holds it until reset.

A debug output marks any request that lasts only a single cycle, which happens when the phase threshold is zero. A synchronizer on the receiving side could miss a pulse that short, so the flag lets a configuration that risks this be found.

Top module: `esc_phase_timer`

## Requirements
- R1: While reset is asserted and right after it is released, all outputs are low: `escReq`, `terminal`, `captured` and `shortPulse`.
- R2: When `trigger` is high and `clear` is low while idle, phase 0 becomes active in the next cycle. A trigger while a phase is active, or while terminal, has no effect on the sequence.
- R3: Phases are visited only in increasing index order, 0 to NumPhases-1, with no index skipped or revisited.
- R4: Phase i stays active for exactly T+1 cycles, where T is the threshold for phase i in bits [32*i +: 32] of `thresholds`. A threshold of zero gives a single-cycle phase.
- R5: `escReq[i]` is high only while phase i is active and `phaseEn[i]` is 1. A disabled phase still keeps its full dwell time with its request low. At most one request bit is high at any time.
- R6: The cycle after the last phase ends, `terminal` goes high. From then until reset it stays high and all `escReq` bits stay low.
- R7: A high `clear` while a phase is active returns the timer to idle in the next cycle. `clear` takes priority over the phase advance and over a trigger that arrives with it. `clear` has no effect once the timer is terminal.
- R8: `captured[i]` goes high in the cycle after a clock edge at which `escReq[i]` was high. It then stays high until reset, and `clear` does not affect it.
- R9: `shortPulse[i]` is high exactly when `escReq[i]` is high and the threshold for phase i is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trigger | input | 1 | Starts the escalation when the timer is idle |
| clear | input | 1 | Aborts the escalation before the terminal state |
| thresholds | input | NumPhases*CntW | Per-phase dwell thresholds, phase i in bits [CntW*i +: CntW] |
| phaseEn | input | NumPhases | Per-phase request enables |
| escReq | output | NumPhases | Per-phase escalation request |
| terminal | output | 1 | High once all phases have run |
| captured | output | NumPhases | Sticky capture of each request, held until reset |
| shortPulse | output | NumPhases | Marks a request that lasts only one cycle |

## Verification
A wrong phase index or a wrong state shows up at once on `escReq`: the wrong bit is high, a bit is missing, or a request sits next to `terminal`. A wrong counter value shows up only at the end of a phase. It shows as a pulse that is too short or too long, so the bench measures each pulse width against threshold+1. A wrong capture register shows on `captured` one cycle after the request it missed. It is most clearly seen after a `clear`, which must leave `captured` unchanged.

// File: rtl/esc_timer_pkg.sv
package esc_timer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_TERM   = 2'd2
  } escState_e;

  // Strobes from the control to the datapath counter
  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } cntStrobe_t;
endpackage

// File: rtl/esc_timer_ctrl.sv
module esc_timer_ctrl
  import esc_timer_pkg::*;
#(
  parameter int NumPhases = 4,
  parameter int IdxW      = $clog2(NumPhases)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trigger,
  input  logic                 clear,
  input  logic                 thrHit,
  input  logic [NumPhases-1:0] phaseEn,
  output cntStrobe_t           strobe,
  output logic [IdxW-1:0]      phaseIdx,
  output logic [NumPhases-1:0] escReq,
  output logic                 terminal
);
  localparam logic [IdxW-1:0] LastIdx = IdxW'(NumPhases - 1);

  escState_e       stateQ, stateD;
  logic [IdxW-1:0] phaseQ, phaseD;

  always_comb begin
    stateD = stateQ;
    phaseD = phaseQ;
    strobe = '{cntClear: 1'b0, cntStep: 1'b0};
    unique case (stateQ)
      ST_IDLE: begin
        strobe.cntClear = 1'b1;
        phaseD = '0;
        if (trigger && !clear) stateD = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (clear) begin
          stateD = ST_IDLE;
          phaseD = '0;
          strobe.cntClear = 1'b1;
        end else if (thrHit) begin
          strobe.cntClear = 1'b1;
          if (phaseQ == LastIdx) stateD = ST_TERM;
          else phaseD = phaseQ + 1'b1;
        end else begin
          strobe.cntStep = 1'b1;
        end
      end
      ST_TERM: strobe.cntClear = 1'b1;
      default: begin
        stateD = ST_TERM;
        strobe.cntClear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      phaseQ <= '0;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
    end
  end

  for (genvar g = 0; g < NumPhases; g++) begin : g_req
    assign escReq[g] = (stateQ == ST_ACTIVE) && (phaseQ == IdxW'(g)) && phaseEn[g];
  end

  assign phaseIdx = phaseQ;
  assign terminal = (stateQ == ST_TERM);

  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && trigger && !clear) |=> (stateQ == ST_ACTIVE && phaseQ == '0));
  a_r3_forward_only: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACTIVE) |=> (stateQ != ST_ACTIVE || phaseQ >= $past(phaseQ)));
  a_r5_one_request: assert property (@(posedge clk) disable iff (!rstN) $onehot0(escReq));
  a_r6_term_hold: assert property (@(posedge clk) disable iff (!rstN)
    terminal |=> (terminal && escReq == '0));
  a_r7_clear_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACTIVE && clear) |=> (stateQ == ST_IDLE));
endmodule

// File: rtl/esc_timer_dpath.sv
module esc_timer_dpath
  import esc_timer_pkg::*;
#(
  parameter int NumPhases = 4,
  parameter int CntW      = 32,
  parameter int IdxW      = $clog2(NumPhases)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  cntStrobe_t                strobe,
  input  logic [IdxW-1:0]           phaseIdx,
  input  logic [NumPhases*CntW-1:0] thresholds,
  input  logic [NumPhases-1:0]      escReq,
  output logic                      thrHit,
  output logic [NumPhases-1:0]      captured,
  output logic [NumPhases-1:0]      shortPulse
);
  logic [CntW-1:0]      thrArr [NumPhases];
  logic [CntW-1:0]      countQ;
  logic [CntW-1:0]      thrSel;
  logic [NumPhases-1:0] capQ;

  for (genvar g = 0; g < NumPhases; g++) begin : g_thr
    assign thrArr[g]     = thresholds[g*CntW +: CntW];
    assign shortPulse[g] = escReq[g] && (thrArr[g] == '0);
  end

  assign thrSel = thrArr[phaseIdx];
  assign thrHit = (countQ == thrSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= '0;
    else if (strobe.cntClear) countQ <= '0;
    else if (strobe.cntStep) countQ <= countQ + 1'b1;
  end

  // Sticky capture as seen by a downstream receiver flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capQ <= '0;
    else capQ <= capQ | escReq;
  end

  assign captured = capQ;

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntStep |=> (countQ == $past(countQ) + 1'b1));
  a_r4_count_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> (countQ == '0));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((captured & $past(captured)) == $past(captured)));
  a_r8_capture: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((captured & $past(escReq)) == $past(escReq)));
endmodule

// File: rtl/esc_phase_timer.sv
module esc_phase_timer
  import esc_timer_pkg::*;
#(
  parameter int NumPhases = 4,
  parameter int CntW      = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      trigger,
  input  logic                      clear,
  input  logic [NumPhases*CntW-1:0] thresholds,
  input  logic [NumPhases-1:0]      phaseEn,
  output logic [NumPhases-1:0]      escReq,
  output logic                      terminal,
  output logic [NumPhases-1:0]      captured,
  output logic [NumPhases-1:0]      shortPulse
);
  localparam int IdxW = $clog2(NumPhases);

  cntStrobe_t      strobe;
  logic            thrHit;
  logic [IdxW-1:0] phaseIdx;

  esc_timer_ctrl #(.NumPhases(NumPhases), .IdxW(IdxW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trigger  (trigger),
    .clear    (clear),
    .thrHit   (thrHit),
    .phaseEn  (phaseEn),
    .strobe   (strobe),
    .phaseIdx (phaseIdx),
    .escReq   (escReq),
    .terminal (terminal)
  );

  esc_timer_dpath #(.NumPhases(NumPhases), .CntW(CntW), .IdxW(IdxW)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .phaseIdx   (phaseIdx),
    .thresholds (thresholds),
    .escReq     (escReq),
    .thrHit     (thrHit),
    .captured   (captured),
    .shortPulse (shortPulse)
  );

  a_r9_short_flag: assert property (@(posedge clk) disable iff (!rstN)
    ((shortPulse & ~escReq) == '0));
endmodule

// File: tb/esc_phase_timer_tb.sv
module esc_phase_timer_tb;
  localparam int N = 4;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigger = 1'b0;
  logic clear = 1'b0;
  logic [N*W-1:0] thresholds = '0;
  logic [N-1:0] phaseEn = '0;
  logic [N-1:0] escReq, captured, shortPulse;
  logic terminal;

  always #2.5 clk = ~clk;

  esc_phase_timer #(.NumPhases(N), .CntW(W)) u_dut (
    .clk(clk), .rstN(rstN), .trigger(trigger), .clear(clear),
    .thresholds(thresholds), .phaseEn(phaseEn), .escReq(escReq),
    .terminal(terminal), .captured(captured), .shortPulse(shortPulse)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Reference model: 0 idle, 1 active, 2 terminal
  int mState = 0;
  int mIdx = 0;
  logic [W-1:0] mCnt = '0;
  logic [N-1:0] mCap = '0;
  logic [W-1:0] nextThr [N];
  logic [N-1:0] nextEn = '0;
  logic [N-1:0] lastReq;
  logic lastTerm;

  function automatic logic [W-1:0] thrOf(int i);
    return thresholds[i*W +: W];
  endfunction

  function automatic logic [N-1:0] modelReq();
    logic [N-1:0] r = '0;
    if (mState == 1 && phaseEn[mIdx]) r[mIdx] = 1'b1;
    return r;
  endfunction

  function automatic logic [N-1:0] modelShort();
    logic [N-1:0] r = modelReq();
    for (int i = 0; i < N; i++) if (thrOf(i) != '0) r[i] = 1'b0;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R5 escReq", 32'(escReq), 32'(modelReq()));
    check("R6 terminal", 32'(terminal), 32'(mState == 2));
    check("R8 captured", 32'(captured), 32'(mCap));
    check("R9 shortPulse", 32'(shortPulse), 32'(modelShort()));
  endtask

  task automatic modelStep();
    mCap = mCap | modelReq();
    case (mState)
      0: if (trigger && !clear) begin mState = 1; mIdx = 0; mCnt = '0; end
      1: begin
        if (clear) begin mState = 0; mIdx = 0; mCnt = '0; end
        else if (mCnt == thrOf(mIdx)) begin
          mCnt = '0;
          if (mIdx == N - 1) mState = 2; else mIdx++;
        end else mCnt++;
      end
      default: ;
    endcase
  endtask

  task automatic cyc(input logic t, input logic c);
    @(negedge clk);
    lastReq = escReq;
    lastTerm = terminal;
    compareAll();
    phaseEn = nextEn;
    for (int i = 0; i < N; i++) thresholds[i*W +: W] = nextThr[i];
    trigger = t;
    clear = c;
    modelStep();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; trigger = 1'b0; clear = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset escReq", 32'(escReq), 0);
    check("R1 reset terminal", 32'(terminal), 0);
    check("R1 reset captured", 32'(captured), 0);
    mState = 0; mIdx = 0; mCnt = '0; mCap = '0;
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int width [N];
    int first [N];
    int termAt;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) nextThr[i] = '0;
    doReset();
    cyc(0, 0);
    check("R1 idle after release", 32'(escReq), 0);

    // Directed: thresholds 0,1,3,2, all enabled
    nextThr[0] = 0; nextThr[1] = 1; nextThr[2] = 3; nextThr[3] = 2;
    nextEn = 4'hF;
    cyc(0, 0);
    cyc(1, 0);
    for (int i = 0; i < N; i++) begin width[i] = 0; first[i] = -1; end
    termAt = -1;
    for (int j = 1; j <= 14; j++) begin
      cyc((j == 3), 0);  // extra trigger mid-run must be ignored (R2)
      for (int i = 0; i < N; i++) if (lastReq[i]) begin
        width[i]++;
        if (first[i] < 0) first[i] = j;
      end
      if (lastTerm && termAt < 0) termAt = j;
    end
    check("R2 phase0 starts next cycle", 32'(first[0]), 1);
    for (int i = 0; i < N; i++) check("R4 dwell width", 32'(width[i]), 32'(nextThr[i] + 1));
    for (int i = 1; i < N; i++) check("R3 order", 32'(first[i] > first[i-1]), 1);
    check("R6 terminal cycle", 32'(termAt), 11);
    cyc(0, 1);
    cyc(1, 0);
    cyc(0, 0);
    check("R7 clear ignored in terminal", 32'(lastTerm), 1);
    check("R6 no request in terminal", 32'(lastReq), 0);

    // Directed: clear mid-run with phases 1,3 enabled
    doReset();
    for (int i = 0; i < N; i++) nextThr[i] = 2;
    nextEn = 4'b1010;
    cyc(0, 0);
    cyc(1, 0);
    for (int j = 1; j <= 4; j++) cyc(0, 0);
    cyc(0, 1);
    cyc(0, 0);
    check("R7 clear to idle", 32'(lastReq), 0);
    check("R8 capture survives clear", 32'(captured), 32'(4'b0010));
    check("R5 disabled phase0 never captured", 32'(captured[0]), 0);
    cyc(1, 1);
    cyc(0, 0);
    check("R7 clear beats trigger", 32'(lastReq | {3'b0, lastTerm}), 0);
    for (int j = 0; j < 20; j++) cyc(0, 0);

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      if (k % 250 == 0) doReset();
      if (mState == 0) begin
        for (int i = 0; i < N; i++) nextThr[i] = W'($urandom_range(0, 5));
        nextEn = N'($urandom_range(0, 15));
      end
      cyc(($urandom_range(0, 9) == 0), ($urandom_range(0, 39) == 0));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule